// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block holds a parameterised set of single-bit mutual-exclusion flags that several processors reach over a plain register bus. Each flag has its own 32-bit word. Reading a word is the acquire step. A read of a free flag returns zero and, in the same clock edge, marks the flag as held. A read of a held flag returns one and leaves it held. Software therefore gets an atomic test-and-set from an ordinary load, and the bus needs no locked or read-modify-write transfer.

A flag is released by writing zero to its word. A read-only word near the bottom of the map reports how many flags the bank carries. The bus has one address for each access, with separate read and write strobes. Read data comes from a register and is valid in the cycle after the read strobe.

Top module: `hw_semaphore_bank`

## Requirements
- R1: After reset every flag is free and `bus_rdata` is zero.
- R2: A read of a free flag at byte address 0x800 + 4*i returns 0 on `bus_rdata` one cycle after the strobe. The flag is held from that same clock edge onward.
- R3: A read of a held flag returns the value 1 (bit 0 set, all other bits zero) and the flag stays held.
- R4: A write of the value 0 to a flag word frees that flag, so the next read of it returns 0.
- R5: A write of any nonzero value to a flag word has no effect on that flag.
- R6: A read of byte address 0x014 returns NUM_LOCKS/32 in bits 31:24 and zero in all other bits. NUM_LOCKS is one of 32, 64, 128 or 256, so exactly one of the field's four low bits is set.
- R7: A read of an unmapped address returns 0 and changes no flag. Unmapped addresses are any address with nonzero bits 1:0, flag indices at or above NUM_LOCKS, and every other address that is neither a flag word nor 0x014. Writes to unmapped addresses and to 0x014 change nothing.
- R8: When a read and a zero write reach the same flag in one cycle, the release is applied first. The read returns 0 and the flag ends up held.
- R9: Two back-to-back reads of a free flag return 0 and then 1.
- R10: In a cycle that follows a cycle with no read strobe, `bus_rdata` is zero.
- R11: An access to one flag never changes any other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, shared by read and write |
| bus_rd | input | 1 | Read strobe (acquire on flag words) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; only the value zero releases a flag |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |

## Verification
The bench targets several corner cases. A read and a zero write to the same flag in one cycle must return 0 and leave the flag held; a design that ordered the acquire before the release would return 1 or leave the flag free. Nonzero writes to a held flag, and misaligned or out-of-range reads aimed inside the flag window, are each followed by a read of the affected flag. This catches a design that released on any write or decoded only part of the address. Back-to-back reads and a long mixed-traffic sequence compared against a behavioural model expose an acquire that lands a cycle late, or any disturbance of a neighbouring flag.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int STATUS_BYTE   = 'h014;
    localparam int LOCK_BASE     = 'h800;
    localparam int COUNT_LSB     = 24;
    localparam int LOCKS_PER_UNIT = 32;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_LOCK   = 2'd2
    } sel_e;

    function automatic logic [7:0] count_field(input int n_locks);
        return 8'(n_locks / LOCKS_PER_UNIT);
    endfunction

endpackage

// File: rtl/sem_addr_decode.sv
module sem_addr_decode
    import sem_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 12,
    parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(LOCK_BASE);
    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_BYTE);
    localparam logic [ADDR_W-1:0] SPAN_A   = ADDR_W'(NUM_LOCKS * 4);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel = addr - BASE_A;
        idx = rel[IDX_W+1:2];
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (addr == STATUS_A) begin
                sel = SEL_STATUS;
            end else if (addr >= BASE_A && rel < SPAN_A) begin
                sel = SEL_LOCK;
            end
        end
    end

endmodule

// File: rtl/sem_lock_array.sv
module sem_lock_array #(
    parameter int NUM_LOCKS = 32,
    parameter int IDX_W     = $clog2(NUM_LOCKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq,
    input  logic             rel,
    input  logic [IDX_W-1:0] idx,
    output logic             prior
);

    typedef struct packed {
        logic [NUM_LOCKS-1:0] held;
    } arr_t;

    arr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rel) begin
            st_d.held[idx] = 1'b0;
        end
        prior = st_d.held[idx];
        if (acq) begin
            st_d.held[idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_acquire_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acq |=> st_q.held[$past(idx)]);

    assert_release_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !acq) |=> !st_q.held[$past(idx)]);

    assert_no_access_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!acq && !rel) |=> $stable(st_q.held));

    assert_single_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.held ^ $past(st_q.held)) <= 1);

endmodule

// File: rtl/hw_semaphore_bank.sv
module hw_semaphore_bank
    import sem_pkg::*;
#(
    parameter int NUM_LOCKS = 32,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int          IDX_W      = $clog2(NUM_LOCKS);
    localparam logic [31:0] STATUS_VAL = {count_field(NUM_LOCKS), 24'h0};

    typedef struct packed {
        logic [31:0] rdata;
    } rd_t;

    sel_e             sel;
    logic [IDX_W-1:0] idx;
    logic             acq, rel, prior;
    rd_t              rd_d, rd_q;

    sem_addr_decode #(
        .NUM_LOCKS (NUM_LOCKS),
        .ADDR_W    (ADDR_W),
        .IDX_W     (IDX_W)
    ) i_decode (
        .addr (bus_addr),
        .sel  (sel),
        .idx  (idx)
    );

    always_comb begin
        acq = bus_rd && (sel == SEL_LOCK);
        rel = bus_wr && (sel == SEL_LOCK) && (bus_wdata == 32'h0);
    end

    sem_lock_array #(
        .NUM_LOCKS (NUM_LOCKS),
        .IDX_W     (IDX_W)
    ) i_locks (
        .clk   (clk),
        .rst_n (rst_n),
        .acq   (acq),
        .rel   (rel),
        .idx   (idx),
        .prior (prior)
    );

    always_comb begin
        rd_d.rdata = 32'h0;
        if (bus_rd) begin
            case (sel)
                SEL_STATUS: rd_d.rdata = STATUS_VAL;
                SEL_LOCK:   rd_d.rdata = {31'h0, prior};
                default:    rd_d.rdata = 32'h0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rdata = rd_q.rdata;

    assert_lock_word_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acq |=> (bus_rdata[31:1] == 31'h0));

    assert_status_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(STATUS_BYTE)) |=>
        (bus_rdata[31:24] == 8'(NUM_LOCKS / 32) && bus_rdata[23:0] == 24'h0));

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == 32'h0));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 32'h0));

    assert_same_cycle_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acq && rel) |=> (bus_rdata == 32'h0));

endmodule

// File: tb/test_hw_semaphore_bank.sv
`timescale 1ns/1ps
module test_hw_semaphore_bank;

    localparam int N      = 32;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_rd;
    logic              bus_wr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit model [N];

    always #10 clk = ~clk;

    hw_semaphore_bank #(.NUM_LOCKS(N), .ADDR_W(ADDR_W)) i_hw_semaphore_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [ADDR_W-1:0] lock_addr(input int i);
        return ADDR_W'('h800 + 4 * i);
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: bus_rdata=%h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: drive after a falling edge, model it, compare at the next falling edge
    task automatic cyc(input logic rd, input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, input string tag);
        logic [31:0] exp;
        int          w;
        bit          is_lock;
        bus_rd    = rd;
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        w         = (int'(a) - 'h800) / 4;
        is_lock   = (a[1:0] == 2'b00) && (int'(a) >= 'h800) && (w < N);
        exp       = 32'h0;
        if (wr && d == 32'h0 && is_lock) model[w] = 1'b0;
        if (rd) begin
            if (int'(a) == 'h014) exp = 32'((N / 32) << 24);
            else if (is_lock) begin
                exp      = {31'h0, model[w]};
                model[w] = 1'b1;
            end
        end
        @(negedge clk);
        check(bus_rdata, exp, tag);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        for (int i = 0; i < N; i++) model[i] = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_rdata, 32'h0, "R1 reset rdata");
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: every flag free after reset, first read acquires
        for (int i = 0; i < N; i++) cyc(1, 0, lock_addr(i), 0, "R1 R2 first read free");
        // R3: second read sees held
        for (int i = 0; i < N; i++) cyc(1, 0, lock_addr(i), 0, "R3 held read");

        // R4, R10, R9
        cyc(0, 1, lock_addr(5), 0, "R10 idle after write");
        cyc(1, 0, lock_addr(5), 0, "R4 R9 read after release");
        cyc(1, 0, lock_addr(5), 0, "R9 back-to-back second read");

        // R5: nonzero write ignored
        cyc(0, 1, lock_addr(7), 32'h1, "R5 nonzero write");
        cyc(0, 1, lock_addr(7), 32'h8000_0000, "R5 nonzero write msb");
        cyc(1, 0, lock_addr(7), 0, "R5 flag still held");

        // release everything
        for (int i = 0; i < N; i++) cyc(0, 1, lock_addr(i), 0, "R4 release all");

        // R11: neighbours untouched
        cyc(1, 0, lock_addr(3), 0, "R11 acquire 3");
        cyc(1, 0, lock_addr(4), 0, "R11 neighbour 4 free");
        cyc(1, 0, lock_addr(2), 0, "R11 neighbour 2 free");
        cyc(0, 1, lock_addr(4), 0, "R11 release 4");
        cyc(1, 0, lock_addr(3), 0, "R11 flag 3 still held");

        // R6 and writes to status
        cyc(1, 0, 12'h014, 0, "R6 status");
        cyc(0, 1, 12'h014, 32'h0, "R7 write status");
        cyc(1, 0, 12'h014, 0, "R6 R7 status unchanged");

        // R7: unmapped reads with no side effect
        cyc(1, 0, 12'h829, 0, "R7 misaligned");
        cyc(1, 0, 12'h82A, 0, "R7 misaligned");
        cyc(1, 0, lock_addr(N), 0, "R7 past last flag");
        cyc(1, 0, 12'h010, 0, "R7 low unmapped");
        cyc(1, 0, 12'h7FC, 0, "R7 below window");
        cyc(1, 0, lock_addr(10), 0, "R7 flag 10 still free");
        cyc(0, 1, 12'h829, 0, "R7 misaligned write");
        cyc(1, 0, lock_addr(10), 0, "R7 flag 10 kept held");
        cyc(1, 0, lock_addr(N - 1), 0, "R2 last flag");

        // R8: same-cycle release and acquire
        cyc(1, 1, lock_addr(3), 0, "R8 release then acquire");
        cyc(1, 0, lock_addr(3), 0, "R8 flag ends held");
        cyc(1, 1, lock_addr(3), 32'h5, "R8 R5 nonzero with read");
        cyc(1, 1, lock_addr(9), 0, "R8 free flag rd+wr");
        cyc(1, 0, lock_addr(9), 0, "R8 free flag ends held");

        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            logic [ADDR_W-1:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = (lfsr[9:8] == 2'b11) ? ADDR_W'({lfsr[7:0], lfsr[1:0]}) : lock_addr(int'(lfsr[4:0]));
            cyc(lfsr[11], lfsr[12], a, lfsr[13] ? 32'h0 : {16'h0, lfsr}, "R2 R3 R4 R11 mixed");
        end

        bus_rd = 0; bus_wr = 0;
        @(negedge clk);
        check(bus_rdata, 32'h0, "R10 final idle");
        done = 1;
        summary();
        $finish;
    end

endmodule